// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns a pair of decoded audio samples (one left, one right) into a three-wire serial stream. The three wires are a bit clock, a word clock that tells the channels apart, and a data line. All three are paced by a 256fs master clock, which the block also generates and drives out. A single control input picks the word format. The format can be a 16-bit word sent most significant bit first, or a 20-bit word sent least significant bit first. It can be changed at run time and takes effect at the next frame.

The block runs on `clk_i`, a tick clock at twice the system clock rate. That is 768fs when the system clock is 384fs, and 1024fs when it is 512fs. Both edges of the system clock are therefore visible as single rising edges. `sel512_i` tells the block which system rate is in use. Each frame has 64 bit-clock periods, 32 for the left channel followed by 32 for the right. Slots that the chosen format does not use are filled with zeros. The sample pair and the format bit are captured at the first master-clock tick of each left half-frame. Inputs may therefore change freely at any other time.

Top module: `pcm_out_fmt`

## Requirements
- R1: With `fmt_i` = 0 at capture, slot s (s = 0..15) of each half-frame carries bit 19−s of that channel's 20-bit sample, so the 16 most significant bits go out MSB first.
- R2: With `fmt_i` = 1 at capture, slot s (s = 0..19) of each half-frame carries bit s of the sample, LSB first.
- R3: `sdata_o` changes only at a slot boundary, together with the falling edge of `bclk_o`, and never while `bclk_o` is high.
- R4: `bclk_o`, `wclk_o` and `sdata_o` change only on the `clk_i` edge at which `mclk_o` rises.
- R5: `wclk_o` is high for the 32 left slots (0..31 of the frame) and low for the 32 right slots (32..63).
- R6: With `sel512_i` = 0, `mclk_o` has a period of 3 `clk_i` cycles, 2 high and 1 low (duty 2:1). With `sel512_i` = 1, the period is 4 cycles, 2 high and 2 low.
- R7: `bclk_o` is `mclk_o` divided by 4. Each slot spans 4 master-clock periods: low for the first two and high for the last two. A frame has 64 slots.
- R8: Unused slots carry 0. These are slots 16..31 of a half-frame in the 16-bit format and slots 20..31 in the 20-bit format.
- R9: `left_i`, `right_i` and `fmt_i` are sampled only at the master-clock tick that starts slot 0 of the left half. Values driven at any other time do not affect the stream until the next frame.
- R10: While `rst_ni` is low, all four outputs are low. The first master-clock tick after reset starts a frame at left slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock, twice the system clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel512_i | input | 1 | 1: 512fs system clock, 0: 384fs |
| fmt_i | input | 1 | 0: 16-bit MSB first, 1: 20-bit LSB first |
| left_i | input | 20 | Left sample |
| right_i | input | 20 | Right sample |
| mclk_o | output | 1 | 256fs master clock |
| bclk_o | output | 1 | Bit clock, 64fs |
| wclk_o | output | 1 | Word clock, high for left |
| sdata_o | output | 1 | Serial data |

## Verification
Every output is a register, so each result becomes visible right after the `clk_i` edge that produces it. `mclk_o` moves on every edge. The three serial lines move only on the edge where `mclk_o` rises. A sample pair presented before the frame-start edge appears in slot 0 on that same edge. The bench counts edges since reset release and derives from that count the master-clock phase, the tick number, the frame and the slot. It compares all four outputs at every falling edge, half a period after the producing edge. It drives fresh samples only ahead of frame-start edges and random junk at all other times, so any early or late capture shows up as a wrong bit.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;
  typedef enum logic {
    FMT_MSB16 = 1'b0,
    FMT_LSB20 = 1'b1
  } fmt_e;
endpackage

// File: rtl/pcm_mclk_gen.sv
// 256fs master clock from a tick clock at 2x system rate.
module pcm_mclk_gen #(
  parameter int HI_CYC  = 2,
  parameter int LO_384  = 1,
  parameter int LO_512  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel512_i,
  output logic mclk_o,
  output logic tick_o
);
  localparam int CNT_W = $clog2(HI_CYC + LO_512);
  localparam logic [CNT_W-1:0] LAST_384 = CNT_W'(HI_CYC + LO_384 - 1);
  localparam logic [CNT_W-1:0] LAST_512 = CNT_W'(HI_CYC + LO_512 - 1);
  localparam logic [CNT_W-1:0] HI_LIM   = CNT_W'(HI_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, last;
  logic             mclk_q;

  assign last    = sel512_i ? LAST_512 : LAST_384;
  assign tick_o  = (cnt_q >= last);
  assign cnt_nxt = tick_o ? '0 : cnt_q + CNT_W'(1);

  // reset into the low phase so the first rise is a tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= HI_LIM;
      mclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      mclk_q <= (cnt_nxt < HI_LIM);
    end
  end

  assign mclk_o = mclk_q;

  AST_MCLK_HIGH_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mclk_o) |=> mclk_o); // R6
  AST_MCLK_LOW_384: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mclk_o && !sel512_i && $stable(sel512_i)) |=> mclk_o); // R6
  AST_MCLK_LOW_512: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mclk_o) && sel512_i && $stable(sel512_i)) |=> !mclk_o); // R6
  AST_TICK_ROSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> $rose(mclk_o)); // R4
endmodule

// File: rtl/pcm_slot_ctr.sv
// Frame position counter: {channel, slot, sub-slot phase}.
module pcm_slot_ctr #(
  parameter int POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [POS_W-1:0] pos_nxt_o
);
  logic [POS_W-1:0] pos_q;

  assign pos_nxt_o = pos_q + POS_W'(1);

  // all ones: first tick lands on position 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '1;
    else if (tick_i) pos_q <= pos_nxt_o;
  end

  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pos_q)); // R4
endmodule

// File: rtl/pcm_bit_pick.sv
// Selects the data bit for one slot in either word format.
module pcm_bit_pick
  import pcm_fmt_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int SHORT_W  = 16,
  parameter int SLOT_W   = 5
) (
  input  logic [SAMPLE_W-1:0] word_i,
  input  fmt_e                fmt_i,
  input  logic [SLOT_W-1:0]   slot_i,
  output logic                bit_o
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [SLOTS-1:0] msb_v, lsb_v;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < SHORT_W) begin : g_msb
      assign msb_v[s] = word_i[SAMPLE_W-1-s];
    end else begin : g_msb_pad
      assign msb_v[s] = 1'b0;
    end
    if (s < SAMPLE_W) begin : g_lsb
      assign lsb_v[s] = word_i[s];
    end else begin : g_lsb_pad
      assign lsb_v[s] = 1'b0;
    end
  end

  assign bit_o = (fmt_i == FMT_LSB20) ? lsb_v[slot_i] : msb_v[slot_i];
endmodule

// File: rtl/pcm_out_fmt.sv
module pcm_out_fmt
  import pcm_fmt_pkg::*;
#(
  parameter int SAMPLE_W     = 20,
  parameter int SHORT_W      = 16,
  parameter int SLOTS_PER_CH = 32,
  parameter int BCLK_DIV     = 4,
  parameter int MCLK_HI      = 2,
  parameter int MCLK_LO_384  = 1,
  parameter int MCLK_LO_512  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel512_i,
  input  logic                fmt_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic                sdata_o
);
  localparam int SLOT_W = $clog2(SLOTS_PER_CH);
  localparam int DIV_W  = $clog2(BCLK_DIV);
  localparam int POS_W  = DIV_W + SLOT_W + 1;

  logic                tick;
  logic [POS_W-1:0]    pos_nxt;
  logic                frame_start, ch_right, data_bit;
  logic [SLOT_W-1:0]   slot;
  logic [SAMPLE_W-1:0] hold_l, hold_r, word_sel;
  fmt_e                hold_fmt, fmt_sel;
  logic                bclk_q, wclk_q, sdata_q;

  pcm_mclk_gen #(
    .HI_CYC (MCLK_HI),
    .LO_384 (MCLK_LO_384),
    .LO_512 (MCLK_LO_512)
  ) u_mclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel512_i (sel512_i),
    .mclk_o   (mclk_o),
    .tick_o   (tick)
  );

  pcm_slot_ctr #(.POS_W(POS_W)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .pos_nxt_o (pos_nxt)
  );

  assign frame_start = tick && (pos_nxt == '0);
  assign ch_right    = pos_nxt[POS_W-1];
  assign slot        = pos_nxt[POS_W-2:DIV_W];

  // slot 0 of left bypasses the holding regs (capture edge)
  assign word_sel = frame_start ? left_i : (ch_right ? hold_r : hold_l);
  assign fmt_sel  = frame_start ? fmt_e'(fmt_i) : hold_fmt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l   <= '0;
      hold_r   <= '0;
      hold_fmt <= FMT_MSB16;
    end else if (frame_start) begin
      hold_l   <= left_i;
      hold_r   <= right_i;
      hold_fmt <= fmt_e'(fmt_i);
    end
  end

  pcm_bit_pick #(
    .SAMPLE_W (SAMPLE_W),
    .SHORT_W  (SHORT_W),
    .SLOT_W   (SLOT_W)
  ) u_pick (
    .word_i (word_sel),
    .fmt_i  (fmt_sel),
    .slot_i (slot),
    .bit_o  (data_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q  <= 1'b0;
      wclk_q  <= 1'b0;
      sdata_q <= 1'b0;
    end else if (tick) begin
      bclk_q  <= pos_nxt[DIV_W-1];
      wclk_q  <= ~ch_right;
      sdata_q <= data_bit;
    end
  end

  assign bclk_o  = bclk_q;
  assign wclk_o  = wclk_q;
  assign sdata_o = sdata_q;

  AST_SDATA_BCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> !bclk_o); // R3
  AST_OUT_ON_MCLK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(bclk_o) || !$stable(wclk_o) || !$stable(sdata_o)) |-> $rose(mclk_o)); // R4
  AST_WCLK_BCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wclk_o) |-> !bclk_o); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> ($stable(hold_l) && $stable(hold_r) && $stable(hold_fmt))); // R9
endmodule

// File: tb/pcm_out_fmt_bench.sv
module pcm_out_fmt_bench;
  localparam int SW = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sel512_i = 1'b0;
  logic          fmt_i = 1'b0;
  logic [SW-1:0] left_i = '0;
  logic [SW-1:0] right_i = '0;
  logic          mclk_o, bclk_o, wclk_o, sdata_o;

  always #4 clk_i = ~clk_i;

  pcm_out_fmt u_pcm_out_fmt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel512_i (sel512_i),
    .fmt_i    (fmt_i),
    .left_i   (left_i),
    .right_i  (right_i),
    .mclk_o   (mclk_o),
    .bclk_o   (bclk_o),
    .wclk_o   (wclk_o),
    .sdata_o  (sdata_o)
  );

  int vectors = 0;
  int miscompares = 0;
  logic          fmt_q[$];
  logic [SW-1:0] l_q[$];
  logic [SW-1:0] r_q[$];

  task automatic chk(string req, string sig, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic push_pair();
    int k;
    logic f;
    logic [SW-1:0] l, r;
    k = fmt_q.size();
    case (k)
      0: begin f = 1'b0; l = 20'hFFFFF; r = 20'h00000; end
      1: begin f = 1'b1; l = 20'h80001; r = 20'h7FFFE; end
      2: begin f = 1'b0; l = 20'h12345; r = 20'hA5A5A; end
      3: begin f = 1'b1; l = 20'hC0003; r = 20'h0F0F0; end
      default: begin f = 1'($urandom); l = 20'($urandom); r = 20'($urandom); end
    endcase
    fmt_q.push_back(f);
    l_q.push_back(l);
    r_q.push_back(r);
    fmt_i = f; left_i = l; right_i = r;
  endtask

  // R9: junk away from the capture edge must not reach the stream
  task automatic junk();
    fmt_i   = 1'($urandom);
    left_i  = 20'($urandom);
    right_i = 20'($urandom);
  endtask

  task automatic drive_for(int tn, int per);
    int n;
    n = (2 + tn) / per;
    if (((2 + tn) % per == 0) && ((n - 1) % 256 == 0)) push_pair();
    else junk();
  endtask

  task automatic expect_at(int tt, int per);
    int n, p, f, s;
    bit rt;
    logic [SW-1:0] w;
    logic eb;
    string rq;
    n = (2 + tt) / per;
    chk("R6", "mclk", mclk_o, ((2 + tt) % per) < 2);
    if (n == 0) begin
      chk("R10", "bclk", bclk_o, 1'b0);
      chk("R10", "wclk", wclk_o, 1'b0);
      chk("R10", "sdata", sdata_o, 1'b0);
    end else begin
      p  = (n - 1) % 256;
      f  = (n - 1) / 256;
      s  = (p / 4) % 32;
      rt = (p >= 128);
      w  = rt ? r_q[f] : l_q[f];
      eb = 1'b0;
      rq = "R8";
      if (!fmt_q[f]) begin
        if (s < 16) begin eb = w[19-s]; rq = "R1/R3/R9"; end
      end else begin
        if (s < 20) begin eb = w[s]; rq = "R2/R3/R9"; end
      end
      chk("R7/R4", "bclk", bclk_o, (p % 4) >= 2);
      chk("R5/R4", "wclk", wclk_o, !rt);
      chk(rq, "sdata", sdata_o, eb);
    end
  endtask

  task automatic run_seg(bit m, int ticks);
    int per;
    per = m ? 4 : 3;
    rst_ni = 1'b0;
    sel512_i = m;
    fmt_q.delete(); l_q.delete(); r_q.delete();
    junk();
    repeat (3) begin
      @(negedge clk_i);
      chk("R10", "mclk", mclk_o, 1'b0);
      chk("R10", "bclk", bclk_o, 1'b0);
      chk("R10", "wclk", wclk_o, 1'b0);
      chk("R10", "sdata", sdata_o, 1'b0);
    end
    drive_for(1, per);
    rst_ni = 1'b1;
    for (int t = 1; ((2 + t) / per) <= ticks; t++) begin
      @(negedge clk_i);
      expect_at(t, per);
      drive_for(t + 1, per);
    end
  endtask

  initial begin
    fork
      begin
        @(negedge clk_i);
        run_seg(1'b0, 6 * 256);
        run_seg(1'b1, 5 * 256 + 77);  // reset lands mid-frame
        run_seg(1'b1, 4 * 256);
        run_seg(1'b0, 3 * 256);
      end
      begin
        #(200000 * 8);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule